// File: doc/BRIEF.md
# I2C Slave Byte Wait and Acknowledge Controller

This block is the per-byte control core of an I2C slave. It watches synchronised SCL samples and counts SCL falling edges within each byte. It pulls SDA low through the ninth clock to acknowledge. It holds SCL low, which stretches the clock and creates a wait, at a chosen falling edge. It raises a one-cycle interrupt pulse at the edge where the wait begins. START and STOP detection, address comparison and SDA data capture live in neighbouring logic. That logic feeds this block with start/stop pulses and with level flags that say whether the address just received is this slave's own address or an extension code.

For data bytes, a control input picks the wait point: the eighth falling edge (before the ACK) or the ninth (after the ACK). Address bytes ignore that input. A matching address always waits at the ninth edge, after an unconditional ACK. An extension code waits at the eighth edge, and its ACK follows the acknowledge-enable input. An address that neither matches nor is an extension code leaves the block idle until the next START. Software ends each wait with a one-cycle release strobe. The bit count then continues from where it stopped. The block has no data stream and so no valid/ready interface. Every pin is plain control or status, and the SCL stretch is the only back-pressure on the bus.

Top module: `i2cs_byte_ctrl`

## Requirements
- R1: While reset is active, and in every cycle after a clock edge at which `enable` was 0, `sda_pull`, `scl_pull` and `irq` are all 0, whatever the SCL activity.
- R2: On a data byte with `wait_late`=0, the eighth SCL falling edge sets `scl_pull` and gives an `irq` pulse. Both appear one clock after the edge is sampled.
- R3: On a data byte with `wait_late`=1, the hold and the `irq` pulse happen at the ninth falling edge instead, and nothing happens at the eighth.
- R4: On an address byte with `addr_match`=1 and `ext_code`=0, the hold and `irq` happen at the ninth falling edge, whatever the value of `wait_late`.
- R5: On an address byte with `ext_code`=1, the hold and `irq` happen at the eighth falling edge, whatever the value of `wait_late`.
- R6: On a data byte, `sda_pull` equals `ack_en` from the eighth falling edge through the whole ninth SCL period, and is 0 after the ninth falling edge.
- R7: On an address byte, the ACK (`sda_pull`=1 over the ninth clock) is given unconditionally for a match. For an extension code it equals `ack_en`.
- R8: An address byte with neither flag set produces no ACK, no hold and no `irq`, and the data bytes that follow it are also ignored until the next `start_pulse`.
- R9: `scl_pull` stays at 1 until a `wait_release` strobe. It is 0 one clock after the strobe, and the following SCL edges continue the count of the same byte.
- R10: `start_pulse` restarts the bit count at zero and makes the next byte an address byte. `stop_pulse` sets `sda_pull` and `scl_pull` to 0 one clock later, even during a wait.
- R11: `irq` is a single-cycle pulse; it is 0 in the cycle after any cycle in which it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Interface enable; 0 clears all state and outputs |
| wait_late | input | 1 | Data-byte wait point: 0 = eighth falling edge, 1 = ninth |
| ack_en | input | 1 | Acknowledge enable for data bytes and extension codes |
| addr_match | input | 1 | Address byte equals the local address (valid by the eighth falling edge) |
| ext_code | input | 1 | Address byte is an extension code (valid by the eighth falling edge) |
| start_pulse | input | 1 | One-cycle START or repeated START indication |
| stop_pulse | input | 1 | One-cycle STOP indication |
| wait_release | input | 1 | One-cycle strobe that ends a wait |
| scl_in | input | 1 | Synchronised SCL line sample |
| scl_pull | output | 1 | Open-drain SCL pull-down enable (clock stretch) |
| sda_pull | output | 1 | Open-drain SDA pull-down enable (ACK) |
| irq | output | 1 | One-cycle per-byte interrupt pulse |

## Verification
On a data byte with `wait_late`=0, the ACK pull-down and the wait/interrupt start on the same eighth falling edge. An extension-code address does the same. The bench makes both appear in one clock cycle by randomising `ack_en` and `wait_late` per byte. At that edge it checks `sda_pull`, `scl_pull` and `irq` together. It then confirms that `sda_pull` stays at the ACK value across the whole stretched ninth clock. A STOP that arrives while a wait and an ACK are both active is also driven. The bench requires both pull-downs to drop in the same cycle.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_e;
endpackage

// File: rtl/i2cs_scl_edge.sv
module i2cs_scl_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  output logic scl_fall
);
  logic scl_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scl_d <= 1'b1;
    else        scl_d <= scl_in;
  end

  assign scl_fall = scl_d & ~scl_in;
endmodule

// File: rtl/i2cs_bit_ctr.sv
module i2cs_bit_ctr #(
  parameter int DATA_BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic scl_fall,
  output logic fall_last,
  output logic fall_ack
);
  localparam int CW = $clog2(DATA_BITS + 1);
  localparam logic [CW-1:0] LAST_IDX = CW'(DATA_BITS - 1);
  localparam logic [CW-1:0] ACK_IDX  = CW'(DATA_BITS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (clr)          cnt_q <= '0;
    else if (scl_fall) begin
      if (cnt_q == ACK_IDX) cnt_q <= '0;
      else                  cnt_q <= cnt_q + 1'b1;
    end
  end

  assign fall_last = scl_fall && (cnt_q == LAST_IDX);
  assign fall_ack  = scl_fall && (cnt_q == ACK_IDX);
endmodule

// File: rtl/i2cs_seq.sv
module i2cs_seq
  import i2cs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic wait_late,
  input  logic ack_en,
  input  logic addr_match,
  input  logic ext_code,
  input  logic start_pulse,
  input  logic stop_pulse,
  input  logic wait_release,
  input  logic fall_last,
  input  logic fall_ack,
  output logic sda_pull,
  output logic scl_pull,
  output logic irq
);
  phase_e phase_q;
  logic   ext_q, sda_q, scl_q, irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      ext_q   <= 1'b0;
      sda_q   <= 1'b0;
      scl_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else if (!enable) begin
      phase_q <= PH_IDLE;
      ext_q   <= 1'b0;
      sda_q   <= 1'b0;
      scl_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (stop_pulse) begin
        phase_q <= PH_IDLE;
        sda_q   <= 1'b0;
        scl_q   <= 1'b0;
      end else if (start_pulse) begin
        phase_q <= PH_ADDR;
        ext_q   <= 1'b0;
        sda_q   <= 1'b0;
        scl_q   <= 1'b0;
      end else begin
        if (wait_release) scl_q <= 1'b0;
        // eighth falling edge: decide ACK, possibly wait early
        if (fall_last) begin
          unique case (phase_q)
            PH_ADDR: begin
              if (ext_code) begin
                ext_q <= 1'b1;
                sda_q <= ack_en;
                scl_q <= 1'b1;
                irq_q <= 1'b1;
              end else if (addr_match) begin
                ext_q <= 1'b0;
                sda_q <= 1'b1;
              end else begin
                phase_q <= PH_IDLE;
              end
            end
            PH_DATA: begin
              sda_q <= ack_en;
              if (!wait_late) begin
                scl_q <= 1'b1;
                irq_q <= 1'b1;
              end
            end
            default: ;
          endcase
        end
        // ninth falling edge: end ACK, possibly wait late
        if (fall_ack) begin
          sda_q <= 1'b0;
          unique case (phase_q)
            PH_ADDR: begin
              phase_q <= PH_DATA;
              if (!ext_q) begin
                scl_q <= 1'b1;
                irq_q <= 1'b1;
              end
            end
            PH_DATA: begin
              if (wait_late) begin
                scl_q <= 1'b1;
                irq_q <= 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign sda_pull = sda_q;
  assign scl_pull = scl_q;
  assign irq      = irq_q;
endmodule

// File: rtl/i2cs_byte_ctrl.sv
module i2cs_byte_ctrl #(
  parameter int DATA_BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic wait_late,
  input  logic ack_en,
  input  logic addr_match,
  input  logic ext_code,
  input  logic start_pulse,
  input  logic stop_pulse,
  input  logic wait_release,
  input  logic scl_in,
  output logic scl_pull,
  output logic sda_pull,
  output logic irq
);
  logic scl_fall, fall_last, fall_ack, ctr_clr;

  assign ctr_clr = !enable || start_pulse || stop_pulse;

  i2cs_scl_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_in   (scl_in),
    .scl_fall (scl_fall)
  );

  i2cs_bit_ctr #(.DATA_BITS(DATA_BITS)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (ctr_clr),
    .scl_fall  (scl_fall),
    .fall_last (fall_last),
    .fall_ack  (fall_ack)
  );

  i2cs_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .wait_late    (wait_late),
    .ack_en       (ack_en),
    .addr_match   (addr_match),
    .ext_code     (ext_code),
    .start_pulse  (start_pulse),
    .stop_pulse   (stop_pulse),
    .wait_release (wait_release),
    .fall_last    (fall_last),
    .fall_ack     (fall_ack),
    .sda_pull     (sda_pull),
    .scl_pull     (scl_pull),
    .irq          (irq)
  );
endmodule

// File: rtl/i2cs_byte_ctrl_chk.sv
module i2cs_byte_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic start_pulse,
  input logic stop_pulse,
  input logic wait_release,
  input logic scl_in,
  input logic scl_pull,
  input logic sda_pull,
  input logic irq
);
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!sda_pull && !scl_pull && !irq)); // R1

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R11

  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_pull && enable && !wait_release && !stop_pulse && !start_pulse) |=> scl_pull); // R9

  AST_WAIT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_pull && wait_release) |=> !scl_pull); // R9

  AST_STOP_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse |=> (!sda_pull && !scl_pull)); // R10

  AST_WAIT_HAS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_pull) |-> irq); // R2

  AST_ACK_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && scl_in && !start_pulse && !stop_pulse) |=> $stable(sda_pull)); // R6
endmodule

bind i2cs_byte_ctrl i2cs_byte_ctrl_chk u_chk (.*);

// File: tb/sim_i2cs_byte_ctrl.sv
module sim_i2cs_byte_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, wait_late = 1'b0, ack_en = 1'b0;
  logic addr_match = 1'b0, ext_code = 1'b0;
  logic start_pulse = 1'b0, stop_pulse = 1'b0, wait_release = 1'b0;
  logic scl_m = 1'b1;
  logic scl_in, scl_pull, sda_pull, irq;
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;
  assign scl_in = scl_m & ~scl_pull;

  i2cs_byte_ctrl u0 (.*);

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_wait(bit is_addr, bit sel, bit wl, bit ext, bit match);
    if (is_addr) return ext ? 8 : (match ? 9 : 0);
    if (!sel) return 0;
    return wl ? 9 : 8;
  endfunction

  function automatic bit exp_ack(bit is_addr, bit sel, bit ae, bit ext, bit match);
    if (is_addr) return ext ? ae : match;
    if (!sel) return 1'b0;
    return ae;
  endfunction

  // clock nine SCL bits; wpos = falling edge index of wait (0 = none)
  task automatic run_byte(int wpos, bit ack, string wreq, string areq);
    for (int k = 1; k <= 9; k++) begin
      scl_m = 1'b1; tick(2);
      if (k == 9) chk(areq, "ack held in ninth clock", sda_pull, ack);
      scl_m = 1'b0; tick(1);
      chk(wreq, "irq at edge", irq, int'(k == wpos));
      chk(wreq, "scl_pull at edge", scl_pull, int'(k == wpos));
      if (k == 8) chk(areq, "ack from eighth edge", sda_pull, ack);
      if (k == 9) chk(areq, "sda freed after ninth edge", sda_pull, 0);
      if (k == wpos) begin
        tick(3);
        chk("R9", "wait still held", scl_pull, 1);
        chk("R11", "irq single cycle", irq, 0);
        wait_release = 1'b1; tick(1); wait_release = 1'b0;
        chk("R9", "released by strobe", scl_pull, 0);
      end
    end
  endtask

  task automatic do_start();
    scl_m = 1'b1; tick(2);
    start_pulse = 1'b1; tick(1); start_pulse = 1'b0;
  endtask

  task automatic do_stop();
    stop_pulse = 1'b1; tick(1); stop_pulse = 1'b0;
    chk("R10", "stop frees scl", scl_pull, 0);
    chk("R10", "stop frees sda", sda_pull, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    tick(3);
    chk("R1", "reset scl_pull", scl_pull, 0);
    chk("R1", "reset sda_pull", sda_pull, 0);
    chk("R1", "reset irq", irq, 0);
    rst_n = 1'b1; tick(2);

    // disabled: full byte with match must do nothing
    addr_match = 1'b1; ack_en = 1'b1;
    do_start();
    run_byte(0, 1'b0, "R1", "R1");
    enable = 1'b1; tick(2);

    // directed: matched address with early wait_late -> ninth edge
    wait_late = 1'b0; addr_match = 1'b1; ext_code = 1'b0; ack_en = 1'b0;
    do_start();
    run_byte(9, 1'b1, "R4", "R7");
    run_byte(8, 1'b0, "R2", "R6");
    do_stop();

    // directed: restart mid-byte restarts the count
    do_start();
    for (int k = 0; k < 3; k++) begin scl_m = 1'b1; tick(2); scl_m = 1'b0; tick(2); end
    do_start();
    run_byte(9, 1'b1, "R10", "R7");
    do_stop();

    // directed: stop during an extension-code wait with ACK active
    ext_code = 1'b1; ack_en = 1'b1; wait_late = 1'b1;
    do_start();
    for (int k = 1; k <= 8; k++) begin scl_m = 1'b1; tick(2); scl_m = 1'b0; tick(1); end
    chk("R5", "ext wait at eighth", scl_pull, 1);
    chk("R7", "ext ack follows ack_en", sda_pull, 1);
    do_stop();

    // directed: unmatched address, following byte ignored
    ext_code = 1'b0; addr_match = 1'b0;
    do_start();
    run_byte(0, 1'b0, "R8", "R8");
    ack_en = 1'b1;
    run_byte(0, 1'b0, "R8", "R8");
    do_stop();

    // random transactions
    for (int t = 0; t < 40; t++) begin
      bit wl, ae, ex, mt, sel;
      int nb;
      wl = 1'($urandom); ae = 1'($urandom);
      ex = ($urandom % 4) == 0; mt = ($urandom % 4) != 0;
      sel = ex | mt;
      wait_late = wl; ack_en = ae; ext_code = ex; addr_match = mt;
      do_start();
      run_byte(exp_wait(1'b1, sel, wl, ex, mt), exp_ack(1'b1, sel, ae, ex, mt),
               ex ? "R5" : (mt ? "R4" : "R8"), sel ? "R7" : "R8");
      nb = 1 + int'($urandom % 3);
      for (int b = 0; b < nb; b++) begin
        wl = 1'($urandom); ae = 1'($urandom);
        wait_late = wl; ack_en = ae;
        ext_code = 1'($urandom); addr_match = 1'($urandom);
        run_byte(exp_wait(1'b0, sel, wl, 1'b0, 1'b0), exp_ack(1'b0, sel, ae, 1'b0, 1'b0),
                 !sel ? "R8" : (wl ? "R3" : "R2"), sel ? "R6" : "R8");
      end
      do_stop();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule